// File: doc/BRIEF.md
# Asynchronous Host Bus Register Interface

This block is a slave port through which an external processor reads and writes a bank of eight-bit registers inside the chip. The processor does not share the system clock. It drives a handful of asynchronous strobes: an active-high address-latch enable, an active-low chip select, and separate active-low read and write strobes. The block passes every strobe through a two-flop synchroniser and takes each action on the synchronised edge. It acknowledges every completed cycle with an active-low ready output, so the processor waits for the block instead of relying on fixed timing.

The address bus is eleven bits wide. The low eight bits pick one of 256 registers. The top three bits form a device-select field, so up to eight of these blocks can share one bus, each strapped to its own identifier. The bidirectional data bus is split into an input, an output and an output enable, which a pad ring combines. A three-bit bus-style input must carry the separate-strobe code. Any other value keeps the block silent.

Top module: `hbus_regif`

## Requirements
- R1: After reset, `rdy_n_o` is 1, `data_oe_o` is 0 and every register reads back 0x00.
- R2: The full 11-bit address is captured on the synchronised high-to-low transition of `ale_i`. Changes on `addr_i` after that capture do not affect which register is accessed.
- R3: A write strobe (`wr_n_i` low, `cs_n_i` low, `rd_n_i` high) to a selected device stores `data_i` into the latched register exactly once per strobe pulse, and a later read returns that value.
- R4: `data_oe_o` is 1 only while `cs_n_i` is 0, `rd_n_i` is 0, `wr_n_i` is 1, the mode is valid and the device matches. It drops as soon as `rd_n_i` or `cs_n_i` returns high. While it is 1, `data_o` carries the latched register's contents.
- R5: `rdy_n_o` is 1 when a strobe is asserted and goes to 0 when the access completes. It stays 0 until the strobes or chip select are released, then returns to 1.
- R6: While `cs_n_i` is 1, read and write strobes are ignored: no register changes, `rdy_n_o` stays 1 and `data_oe_o` stays 0.
- R7: The block responds only when latched address bits [10:8] equal `dev_id_i`. Otherwise no register changes, `rdy_n_o` stays 1 and `data_oe_o` stays 0.
- R8: The block is active only when `mode_i` equals 3'b000 (separate read and write strobes). For any other value, no register changes, `rdy_n_o` stays 1 and `data_oe_o` stays 0.
- R9: If `rd_n_i` and `wr_n_i` are low together with `cs_n_i` low, the cycle is ignored. No register changes and `rdy_n_o` stays 1 until both strobes are high again.
- R10: With the default `ACK_LAT` of 2, suppose a strobe changes half a cycle before a rising clock edge. Then `rdy_n_o` falls on the fifth rising edge after that change (two synchroniser stages, one decode cycle, two completion cycles). After the strobe is released, `rdy_n_o` rises on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Bus-style strap; 3'b000 selects separate read/write strobes |
| dev_id_i | input | 3 | Device identifier compared with address bits [10:8] |
| cs_n_i | input | 1 | Active-low chip select (asynchronous) |
| ale_i | input | 1 | Active-high address-latch enable; address taken on its fall |
| rd_n_i | input | 1 | Active-low read strobe (asynchronous) |
| wr_n_i | input | 1 | Active-low write strobe (asynchronous) |
| addr_i | input | 11 | Device select [10:8] and register address [7:0] |
| data_i | input | 8 | Write data from the host |
| data_o | output | 8 | Read data toward the host |
| data_oe_o | output | 1 | Drive enable for the data pads |
| rdy_n_o | output | 1 | Active-low cycle-complete indication |

## Verification
Two functions can meet in one synchronised cycle: a read request and a write request. The bench provokes this by pulling both strobes low together with chip select low on a matching device. It then judges the outcome at the ports: ready must stay high for the whole overlap, and a read afterwards must return the register's previous value. A second overlap comes from the address latch. The bench changes the address bus right after the latch enable falls, then confirms that the write lands at the captured register and that the register at the new bus value is untouched.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    // Control sequencer states for one host access
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for a qualified strobe
        ST_BUSY  = 2'd1,  // access in progress, completion counter running
        ST_DONE  = 2'd2,  // ready shown, waiting for strobe release
        ST_BLOCK = 2'd3   // conflicting strobes, waiting for release
    } hb_state_e;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q, stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end

        assign sync_o[b] = stab_q;
    end

endmodule

// File: rtl/hbus_regbank.sv
module hbus_regbank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic [DW-1:0] ent_d;
        logic          hit;

        always_comb begin
            hit   = we_i && (addr_i == AW'(e));
            ent_d = hit ? wdata_i : mem_q[e];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[e] <= '0;
            else        mem_q[e] <= ent_d;
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int          REG_AW   = 8,
    parameter int          SEL_W    = 3,
    parameter int          ACK_LAT  = 2,
    parameter logic [2:0]  MODE_SEP = 3'b000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                mode_i,
    input  logic [SEL_W-1:0]          dev_id_i,
    input  logic                      cs_s_i,
    input  logic                      ale_s_i,
    input  logic                      rd_s_i,
    input  logic                      wr_s_i,
    input  logic [REG_AW+SEL_W-1:0]   addr_i,
    output logic [REG_AW-1:0]         reg_addr_o,
    output logic                      active_o,
    output logic                      we_o,
    output logic                      rdy_n_o
);

    localparam int FULL_AW = REG_AW + SEL_W;
    localparam int CNT_W   = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ACK_LAT - 1);

    typedef struct packed {
        hb_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [FULL_AW-1:0] addr;
        logic               ale_prev;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic sel_ok, rd_go, wr_go, released;

    assign active_o = (mode_i == MODE_SEP) &&
                      (r_q.addr[FULL_AW-1:REG_AW] == dev_id_i);

    always_comb begin
        r_d      = r_q;
        we_o     = 1'b0;
        sel_ok   = !cs_s_i && active_o;
        rd_go    = sel_ok && !rd_s_i;
        wr_go    = sel_ok && !wr_s_i;
        released = cs_s_i || (rd_s_i && wr_s_i);

        // address capture on the falling latch enable
        r_d.ale_prev = ale_s_i;
        if (r_q.ale_prev && !ale_s_i) begin
            r_d.addr = addr_i;
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (rd_go && wr_go) begin
                    r_d.state = ST_BLOCK;
                end else if (wr_go) begin
                    we_o      = 1'b1;
                    r_d.state = ST_BUSY;
                    r_d.cnt   = '0;
                end else if (rd_go) begin
                    r_d.state = ST_BUSY;
                    r_d.cnt   = '0;
                end
            end
            ST_BUSY: begin
                if (released) begin
                    r_d.state = ST_IDLE;
                end else if (r_q.cnt == CNT_END) begin
                    r_d.state = ST_DONE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DONE: begin
                if (released) r_d.state = ST_IDLE;
            end
            ST_BLOCK: begin
                if (released) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, addr: '0, ale_prev: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_addr_o = r_q.addr[REG_AW-1:0];
    assign rdy_n_o    = (r_q.state != ST_DONE);

endmodule

// File: rtl/hbus_regif.sv
module hbus_regif #(
    parameter int          REG_AW   = 8,
    parameter int          DW       = 8,
    parameter int          SEL_W    = 3,
    parameter int          ACK_LAT  = 2,
    parameter logic [2:0]  MODE_SEP = 3'b000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                mode_i,
    input  logic [SEL_W-1:0]          dev_id_i,
    input  logic                      cs_n_i,
    input  logic                      ale_i,
    input  logic                      rd_n_i,
    input  logic                      wr_n_i,
    input  logic [REG_AW+SEL_W-1:0]   addr_i,
    input  logic [DW-1:0]             data_i,
    output logic [DW-1:0]             data_o,
    output logic                      data_oe_o,
    output logic                      rdy_n_o
);

    // synchroniser bit order: {ale, wr_n, rd_n, cs_n}
    localparam int         NSYNC    = 4;
    localparam logic [3:0] SYNC_RST = 4'b0111;

    logic [NSYNC-1:0]  sync_vec;
    logic              cs_sync, rd_sync, wr_sync, ale_sync;
    logic [REG_AW-1:0] reg_addr;
    logic              dev_active;
    logic              bank_we;

    hbus_sync #(
        .W       (NSYNC),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ale_i, wr_n_i, rd_n_i, cs_n_i}),
        .sync_o  (sync_vec)
    );

    assign cs_sync  = sync_vec[0];
    assign rd_sync  = sync_vec[1];
    assign wr_sync  = sync_vec[2];
    assign ale_sync = sync_vec[3];

    hbus_ctrl #(
        .REG_AW   (REG_AW),
        .SEL_W    (SEL_W),
        .ACK_LAT  (ACK_LAT),
        .MODE_SEP (MODE_SEP)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .dev_id_i   (dev_id_i),
        .cs_s_i     (cs_sync),
        .ale_s_i    (ale_sync),
        .rd_s_i     (rd_sync),
        .wr_s_i     (wr_sync),
        .addr_i     (addr_i),
        .reg_addr_o (reg_addr),
        .active_o   (dev_active),
        .we_o       (bank_we),
        .rdy_n_o    (rdy_n_o)
    );

    hbus_regbank #(
        .AW (REG_AW),
        .DW (DW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bank_we),
        .addr_i  (reg_addr),
        .wdata_i (data_i),
        .rdata_o (data_o)
    );

    // pad drive follows the raw strobes so it is released without delay
    assign data_oe_o = dev_active && !cs_n_i && !rd_n_i && wr_n_i;

endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk #(
    parameter logic [2:0] MODE_SEP = 3'b000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       cs_n_i,
    input logic       rd_n_i,
    input logic       wr_n_i,
    input logic       data_oe_o,
    input logic       rdy_n_o,
    input logic       bank_we,
    input logic       dev_active,
    input logic       cs_sync,
    input logic       rd_sync
);

    // R4
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (!cs_n_i && !rd_n_i && wr_n_i));

    // R8
    rdy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n_o |-> (mode_i == MODE_SEP));

    // R3
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> !bank_we);

    // R7
    write_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> dev_active);

    // R9
    write_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> rd_sync);

    // R6
    write_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> !cs_sync);

    // R5
    write_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> rdy_n_o);

endmodule

bind hbus_regif hbus_regif_chk #(.MODE_SEP(MODE_SEP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .wr_n_i     (wr_n_i),
    .data_oe_o  (data_oe_o),
    .rdy_n_o    (rdy_n_o),
    .bank_we    (bank_we),
    .dev_active (dev_active),
    .cs_sync    (cs_sync),
    .rd_sync    (rd_sync)
);

// File: tb/hbus_regif_bench.sv
`timescale 1ns/1ps
module hbus_regif_bench;

    localparam logic [2:0] MY_ID = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'b000;
    logic [2:0]  dev_id_i = MY_ID;
    logic        cs_n_i = 1'b1;
    logic        ale_i = 1'b0;
    logic        rd_n_i = 1'b1;
    logic        wr_n_i = 1'b1;
    logic [10:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic        rdy_n_o;

    always #5 clk = ~clk;

    hbus_regif u_hbus_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .dev_id_i  (dev_id_i),
        .cs_n_i    (cs_n_i),
        .ale_i     (ale_i),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .addr_i    (addr_i),
        .data_i    (data_i),
        .data_o    (data_o),
        .data_oe_o (data_oe_o),
        .rdy_n_o   (rdy_n_o)
    );

    // reference model and scoreboard
    logic [7:0] model [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    int n_vec = 0, n_err = 0;
    int mon_vec = 0, mon_err = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare read data on the first ready-low cycle with the pad driven
    logic rdy_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n && !rdy_n_o && rdy_prev && data_oe_o) begin
            mon_vec++;
            if (exp_q.size() == 0) begin
                mon_err++;
                $display("FAIL R4 actual=%0h expected=none (unexpected read result)", data_o);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (data_o !== e) begin
                    mon_err++;
                    $display("FAIL %s actual=%0h expected=%0h", t, data_o, e);
                end
            end
        end
        rdy_prev = rdy_n_o;
    end

    task automatic latch_addr(input logic [10:0] a, input logic [10:0] after);
        @(negedge clk);
        addr_i = a;
        ale_i  = 1'b1;
        repeat (3) @(negedge clk);
        ale_i = 1'b0;
        repeat (4) @(negedge clk);
        addr_i = after;
    endtask

    task automatic wait_rdy_low(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (!rdy_n_o) seen = 1'b1;
        end
    endtask

    task automatic release_all();
        @(negedge clk);
        rd_n_i = 1'b1;
        wr_n_i = 1'b1;
        cs_n_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // effective write that must complete
    task automatic bus_write(input logic [10:0] a, input logic [7:0] d, input string req);
        bit seen;
        latch_addr(a, ~a);
        data_i = d;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        wait_rdy_low(seen);
        check(seen, req, seen, 1);
        model[a[7:0]] = d;
        release_all();
    endtask

    // read that must complete; expected value goes to the scoreboard
    task automatic bus_read(input logic [10:0] a, input string req);
        bit seen;
        latch_addr(a, ~a);
        exp_q.push_back(model[a[7:0]]);
        tag_q.push_back(req);
        cs_n_i = 1'b0;
        rd_n_i = 1'b0;
        #1 check(data_oe_o === 1'b1, "R4", data_oe_o, 1);
        wait_rdy_low(seen);
        check(seen, req, seen, 1);
        @(negedge clk);
        rd_n_i = 1'b1;
        #1 check(data_oe_o === 1'b0, "R4", data_oe_o, 0);
        cs_n_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // stimulus that must be ignored: ready stays high, pad stays off
    task automatic bus_ignored(input logic [10:0] a, input bit csn, input bit rdn,
                               input bit wrn, input logic [7:0] d, input string req);
        bit rdy_seen = 1'b0, oe_seen = 1'b0;
        latch_addr(a, ~a);
        data_i = d;
        cs_n_i = csn;
        rd_n_i = rdn;
        wr_n_i = wrn;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!rdy_n_o) rdy_seen = 1'b1;
            if (data_oe_o) oe_seen = 1'b1;
        end
        check(!rdy_seen, req, rdy_seen, 0);
        check(!oe_seen, req, oe_seen, 0);
        release_all();
    endtask

    task automatic run_tests();
        bit seen;
        int n;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;

        // R1 reset state
        repeat (5) @(negedge clk);
        check(rdy_n_o === 1'b1, "R1", rdy_n_o, 1);
        check(data_oe_o === 1'b0, "R1", data_oe_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(rdy_n_o === 1'b1, "R1", rdy_n_o, 1);
        bus_read({MY_ID, 8'h00}, "R1");
        bus_read({MY_ID, 8'hFF}, "R1");

        // R3 / R4 write and read back patterns
        bus_write({MY_ID, 8'h00}, 8'hA5, "R3");
        bus_write({MY_ID, 8'hFF}, 8'hFF, "R3");
        bus_write({MY_ID, 8'h3C}, 8'h5A, "R3");
        bus_write({MY_ID, 8'h3C}, 8'h00, "R3");
        bus_write({MY_ID, 8'h81}, 8'h7E, "R3");
        bus_read({MY_ID, 8'h00}, "R3");
        bus_read({MY_ID, 8'hFF}, "R3");
        bus_read({MY_ID, 8'h3C}, "R3");
        bus_read({MY_ID, 8'h81}, "R4");

        // R2 bus changes after the latch enable falls
        latch_addr({MY_ID, 8'h10}, {MY_ID, 8'h20});
        data_i = 8'hC3;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        wait_rdy_low(seen);
        check(seen, "R2", seen, 1);
        model[8'h10] = 8'hC3;
        release_all();
        bus_read({MY_ID, 8'h10}, "R2");
        bus_read({MY_ID, 8'h20}, "R2");

        // R6 chip select high
        bus_ignored({MY_ID, 8'h00}, 1'b1, 1'b1, 1'b0, 8'h11, "R6");
        bus_ignored({MY_ID, 8'h00}, 1'b1, 1'b0, 1'b1, 8'h11, "R6");
        bus_read({MY_ID, 8'h00}, "R6");

        // R7 other device selected
        bus_ignored({3'd3, 8'hFF}, 1'b0, 1'b1, 1'b0, 8'h22, "R7");
        bus_ignored({3'd3, 8'hFF}, 1'b0, 1'b0, 1'b1, 8'h22, "R7");
        bus_read({MY_ID, 8'hFF}, "R7");

        // R8 unsupported bus style
        mode_i = 3'b001;
        bus_ignored({MY_ID, 8'h81}, 1'b0, 1'b1, 1'b0, 8'h33, "R8");
        mode_i = 3'b100;
        bus_ignored({MY_ID, 8'h81}, 1'b0, 1'b0, 1'b1, 8'h33, "R8");
        mode_i = 3'b000;
        bus_read({MY_ID, 8'h81}, "R8");

        // R9 both strobes together
        bus_ignored({MY_ID, 8'h3C}, 1'b0, 1'b0, 1'b0, 8'h44, "R9");
        bus_read({MY_ID, 8'h3C}, "R9");

        // R10 / R5 exact ready timing on a write
        latch_addr({MY_ID, 8'h55}, {MY_ID, 8'h55});
        data_i = 8'h9D;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        #1 check(rdy_n_o === 1'b1, "R5", rdy_n_o, 1);
        n = 0;
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!rdy_n_o) seen = 1'b1;
        end
        check(n == 5, "R10", n, 5);
        model[8'h55] = 8'h9D;
        repeat (4) @(negedge clk);
        check(rdy_n_o === 1'b0, "R5", rdy_n_o, 0);
        wr_n_i = 1'b1;
        cs_n_i = 1'b1;
        n = 0;
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rdy_n_o) seen = 1'b1;
        end
        check(n == 3, "R10", n, 3);
        repeat (4) @(negedge clk);
        check(rdy_n_o === 1'b1, "R5", rdy_n_o, 1);
        bus_read({MY_ID, 8'h55}, "R10");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4", exp_q.size(), 0);
    endtask

    initial begin
        bit wd_hit = 1'b0;
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec + mon_vec, n_err + mon_err);
        $finish;
    end

endmodule